// File: doc/BRIEF.md
# Paired-Instruction Fetch Sequencer

This block is the fetch and sequencing front end of an accumulator machine. Every 40-bit memory word holds two 20-bit instructions. Each instruction is an 8-bit opcode followed by a 12-bit operand address. The sequencer reads one word through an address register into a buffer register, then splits that word into its two halves. It issues the left instruction first. It keeps the right instruction in a holding register, so the right instruction later issues without a second memory access. Only after the right half has issued does the program counter, which counts instruction pairs, step to the next word.

Each issued instruction goes to an execute stage over a valid/ready handshake. In the same cycle that it accepts an instruction, the execute stage may request a branch. A branch request carries a target word address and a flag that selects the left or right half of that word. Memory is single-ported and returns read data one cycle after a read strobe. A fetch from a word address beyond the last legal word sets a sticky error flag and halts the sequencer until reset.

Top module: `paired_fetch_seq`

## Requirements
- R1: Synchronous reset (`rst` high) clears the program counter to 0, empties the holding register and clears `err_halt`. During reset `iss_valid` and `mem_rd` are low. The first read after reset is at word 0.
- R2: In a fetched word the left instruction is bits 39:20 and the right instruction is bits 19:0. In each instruction the opcode is the upper 8 bits and the operand address is the lower 12 bits. `iss_right` is 0 for a left instruction and 1 for a right instruction.
- R3: A left instruction issues only after exactly one memory read, whose address is the program counter.
- R4: A right instruction that follows its own left half issues from the holding register with no memory read.
- R5: After the right half of a word is accepted without a branch, the next read is at the following word address, so a straight-line program reads words 0, 1, 2, ...
- R6: While `iss_valid` is high and `iss_ready` is low, `iss_valid`, `iss_op`, `iss_addr` and `iss_right` stay unchanged.
- R7: A branch with `br_right` = 0, accepted together with an issue, discards the held right instruction. The next read is then at `br_target`, and the left instruction of that word issues.
- R8: A branch with `br_right` = 1 reads word `br_target` and issues only its right instruction. The next read is at `br_target` + 1.
- R9: A fetch that needs a read at a word address of 1000 or more sets `err_halt`. After that no read strobe and no issue occur, and `err_halt` stays high until reset.
- R10: `mem_rd` is a single-cycle strobe. The word is taken from `mem_rdata` in the cycle after the strobe and not at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 12 | Word address of the read |
| mem_rdata | input | 40 | Read data, valid one cycle after the strobe |
| iss_valid | output | 1 | An instruction is offered to the execute stage |
| iss_ready | input | 1 | The execute stage accepts the offered instruction |
| iss_op | output | 8 | Opcode of the offered instruction |
| iss_addr | output | 12 | Operand address of the offered instruction |
| iss_right | output | 1 | 1 when the offered instruction is the right half |
| br_valid | input | 1 | Branch request, sampled only on an accepted issue |
| br_target | input | 12 | Word address of the branch target |
| br_right | input | 1 | Branch enters the target word at its right half |
| err_halt | output | 1 | Sticky fetch-range error; the sequencer is halted |

## Verification
The assertions take two things about the inputs for granted. First, the memory answers every strobe in exactly the next cycle. Second, the execute stage raises `br_valid` only in a cycle where it also accepts an instruction, because a branch request at any other time is ignored by design. The bench's memory model returns the computed word only in the cycle after a strobe and a fixed filler value otherwise, so a capture in the wrong cycle shows up as a field mismatch. The execute model asserts `br_valid` only while `iss_valid` and `iss_ready` are both high. It withholds `iss_ready` on a fixed rhythm so that held offers are exercised.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

   typedef enum logic [2:0] {
      PH_FETCH   = 3'd0,
      PH_READ    = 3'd1,
      PH_CAPTURE = 3'd2,
      PH_SPLIT   = 3'd3,
      PH_ISSUE   = 3'd4,
      PH_HALT    = 3'd5
   } pfs_phase_e;

   localparam bit HALF_LEFT  = 1'b0;
   localparam bit HALF_RIGHT = 1'b1;

endpackage

// File: rtl/pfs_pair_counter.sv
module pfs_pair_counter #(
   parameter int ADDR_W = 12,
   parameter int DEPTH  = 1000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              step,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   output logic [ADDR_W-1:0] pair_addr,
   output logic              out_of_range
);

   localparam logic [ADDR_W-1:0] LAST_WORD = ADDR_W'(DEPTH - 1);

   logic [ADDR_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (step) begin
         cnt_q <= cnt_q + ADDR_W'(1);
      end
   end

   assign pair_addr    = cnt_q;
   assign out_of_range = (cnt_q > LAST_WORD);

   AST_NO_STEP_AND_LOAD: assert property (@(posedge clk) disable iff (rst)
      !(step && load)); // R7

   AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (rst)
      (step && !load) |=> (cnt_q == $past(cnt_q) + ADDR_W'(1))); // R5

endmodule

// File: rtl/pfs_word_split.sv
module pfs_word_split #(
   parameter int OP_W          = 8,
   parameter int ADDR_W        = 12,
   parameter bit FIRST_IN_HIGH = 1'b1,
   localparam int INSN_W       = OP_W + ADDR_W,
   localparam int WORD_W       = 2 * INSN_W
) (
   input  logic [WORD_W-1:0] word,
   output logic [OP_W-1:0]   first_op,
   output logic [ADDR_W-1:0] first_addr,
   output logic [INSN_W-1:0] second_insn
);

   logic [INSN_W-1:0] first_insn;

   generate
      if (FIRST_IN_HIGH) begin : g_first_high
         assign first_insn  = word[WORD_W-1:INSN_W];
         assign second_insn = word[INSN_W-1:0];
      end else begin : g_first_low
         assign first_insn  = word[INSN_W-1:0];
         assign second_insn = word[WORD_W-1:INSN_W];
      end
   endgenerate

   assign first_op   = first_insn[INSN_W-1:ADDR_W];
   assign first_addr = first_insn[ADDR_W-1:0];

endmodule

// File: rtl/pfs_sequencer.sv
module pfs_sequencer
   import pfs_pkg::*;
#(
   parameter int OP_W   = 8,
   parameter int ADDR_W = 12,
   localparam int INSN_W = OP_W + ADDR_W,
   localparam int WORD_W = 2 * INSN_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] pair_addr,
   input  logic              pair_oob,
   output logic              pair_step,
   output logic              pair_load,
   output logic [ADDR_W-1:0] pair_load_val,
   output logic [WORD_W-1:0] buf_word,
   input  logic [OP_W-1:0]   left_op,
   input  logic [ADDR_W-1:0] left_addr,
   input  logic [INSN_W-1:0] right_insn,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              iss_valid,
   input  logic              iss_ready,
   output logic [OP_W-1:0]   iss_op,
   output logic [ADDR_W-1:0] iss_addr,
   output logic              iss_right,
   input  logic              br_valid,
   input  logic [ADDR_W-1:0] br_target,
   input  logic              br_right,
   output logic              err_halt
);

   pfs_phase_e        phase_q;
   logic [ADDR_W-1:0] mar_q;
   logic [WORD_W-1:0] mbr_q;
   logic [OP_W-1:0]   ir_q;
   logic              ir_half_q;
   logic [INSN_W-1:0] hold_q;
   logic              hold_vld_q;
   logic              enter_right_q;
   logic              err_q;
   logic              accept;

   assign accept        = (phase_q == PH_ISSUE) && iss_ready;
   assign pair_load     = accept && br_valid;
   assign pair_load_val = br_target;
   assign pair_step     = ((phase_q == PH_FETCH) && hold_vld_q)
                        || ((phase_q == PH_SPLIT) && enter_right_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q       <= PH_FETCH;
         mar_q         <= '0;
         mbr_q         <= '0;
         ir_q          <= '0;
         ir_half_q     <= HALF_LEFT;
         hold_q        <= '0;
         hold_vld_q    <= 1'b0;
         enter_right_q <= 1'b0;
         err_q         <= 1'b0;
      end else begin
         unique case (phase_q)
            PH_FETCH: begin
               if (hold_vld_q) begin
                  ir_q       <= hold_q[INSN_W-1:ADDR_W];
                  mar_q      <= hold_q[ADDR_W-1:0];
                  ir_half_q  <= HALF_RIGHT;
                  hold_vld_q <= 1'b0;
                  phase_q    <= PH_ISSUE;
               end else if (pair_oob) begin
                  err_q   <= 1'b1;
                  phase_q <= PH_HALT;
               end else begin
                  mar_q   <= pair_addr;
                  phase_q <= PH_READ;
               end
            end
            PH_READ: begin
               phase_q <= PH_CAPTURE;
            end
            PH_CAPTURE: begin
               mbr_q   <= mem_rdata;
               phase_q <= PH_SPLIT;
            end
            PH_SPLIT: begin
               if (enter_right_q) begin
                  ir_q          <= right_insn[INSN_W-1:ADDR_W];
                  mar_q         <= right_insn[ADDR_W-1:0];
                  ir_half_q     <= HALF_RIGHT;
                  enter_right_q <= 1'b0;
               end else begin
                  ir_q       <= left_op;
                  mar_q      <= left_addr;
                  ir_half_q  <= HALF_LEFT;
                  hold_q     <= right_insn;
                  hold_vld_q <= 1'b1;
               end
               phase_q <= PH_ISSUE;
            end
            PH_ISSUE: begin
               if (accept) begin
                  if (br_valid) begin
                     hold_vld_q    <= 1'b0;
                     enter_right_q <= br_right;
                  end
                  phase_q <= PH_FETCH;
               end
            end
            PH_HALT: begin
               phase_q <= PH_HALT;
            end
            default: begin
               phase_q <= PH_HALT;
               err_q   <= 1'b1;
            end
         endcase
      end
   end

   assign buf_word  = mbr_q;
   assign mem_rd    = (phase_q == PH_READ);
   assign mem_addr  = mar_q;
   assign iss_valid = (phase_q == PH_ISSUE);
   assign iss_op    = ir_q;
   assign iss_addr  = mar_q;
   assign iss_right = ir_half_q;
   assign err_halt  = err_q;

   AST_OFFER_HELD: assert property (@(posedge clk) disable iff (rst)
      (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_op)
                                     && $stable(iss_addr) && $stable(iss_right))); // R6

   AST_READ_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      mem_rd |=> !mem_rd); // R10

   AST_NO_OFFER_WHILE_READING: assert property (@(posedge clk) disable iff (rst)
      mem_rd |=> !iss_valid); // R10

   AST_HALT_SILENT: assert property (@(posedge clk) disable iff (rst)
      err_halt |-> (!mem_rd && !iss_valid)); // R9

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
      err_halt |=> err_halt); // R9

   AST_HELD_ISSUE_NO_READ: assert property (@(posedge clk) disable iff (rst)
      ((phase_q == PH_FETCH) && hold_vld_q) |=> (iss_valid && iss_right && !mem_rd)); // R4

endmodule

// File: rtl/paired_fetch_seq.sv
module paired_fetch_seq #(
   parameter int OP_W          = 8,
   parameter int ADDR_W        = 12,
   parameter int DEPTH         = 1000,
   parameter bit LEFT_IN_HIGH  = 1'b1,
   localparam int INSN_W       = OP_W + ADDR_W,
   localparam int WORD_W       = 2 * INSN_W
) (
   input  logic              clk,
   input  logic              rst,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              iss_valid,
   input  logic              iss_ready,
   output logic [OP_W-1:0]   iss_op,
   output logic [ADDR_W-1:0] iss_addr,
   output logic              iss_right,
   input  logic              br_valid,
   input  logic [ADDR_W-1:0] br_target,
   input  logic              br_right,
   output logic              err_halt
);

   generate
      if (OP_W < 1 || ADDR_W < 1) begin : g_bad_width
         $error("paired_fetch_seq: field widths must be positive");
      end
      if (DEPTH < 1 || DEPTH > (1 << ADDR_W)) begin : g_bad_depth
         $error("paired_fetch_seq: DEPTH must fit the address field");
      end
   endgenerate

   logic [ADDR_W-1:0] pair_addr;
   logic              pair_oob;
   logic              pair_step;
   logic              pair_load;
   logic [ADDR_W-1:0] pair_load_val;
   logic [WORD_W-1:0] buf_word;
   logic [OP_W-1:0]   left_op;
   logic [ADDR_W-1:0] left_addr;
   logic [INSN_W-1:0] right_insn;

   pfs_pair_counter #(
      .ADDR_W (ADDR_W),
      .DEPTH  (DEPTH)
   ) u_pc (
      .clk          (clk),
      .rst          (rst),
      .step         (pair_step),
      .load         (pair_load),
      .load_val     (pair_load_val),
      .pair_addr    (pair_addr),
      .out_of_range (pair_oob)
   );

   pfs_word_split #(
      .OP_W          (OP_W),
      .ADDR_W        (ADDR_W),
      .FIRST_IN_HIGH (LEFT_IN_HIGH)
   ) u_split (
      .word        (buf_word),
      .first_op    (left_op),
      .first_addr  (left_addr),
      .second_insn (right_insn)
   );

   pfs_sequencer #(
      .OP_W   (OP_W),
      .ADDR_W (ADDR_W)
   ) u_seq (
      .clk           (clk),
      .rst           (rst),
      .pair_addr     (pair_addr),
      .pair_oob      (pair_oob),
      .pair_step     (pair_step),
      .pair_load     (pair_load),
      .pair_load_val (pair_load_val),
      .buf_word      (buf_word),
      .left_op       (left_op),
      .left_addr     (left_addr),
      .right_insn    (right_insn),
      .mem_rd        (mem_rd),
      .mem_addr      (mem_addr),
      .mem_rdata     (mem_rdata),
      .iss_valid     (iss_valid),
      .iss_ready     (iss_ready),
      .iss_op        (iss_op),
      .iss_addr      (iss_addr),
      .iss_right     (iss_right),
      .br_valid      (br_valid),
      .br_target     (br_target),
      .br_right      (br_right),
      .err_halt      (err_halt)
   );

   AST_READ_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
      mem_rd |-> (mem_addr < ADDR_W'(DEPTH))); // R9

endmodule

// File: tb/paired_fetch_seq_tb.sv
module paired_fetch_seq_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        mem_rd;
   logic [11:0] mem_addr;
   logic [39:0] mem_rdata = '0;
   logic        iss_valid;
   logic        iss_ready = 1'b0;
   logic [7:0]  iss_op;
   logic [11:0] iss_addr;
   logic        iss_right;
   logic        br_valid = 1'b0;
   logic [11:0] br_target = '0;
   logic        br_right = 1'b0;
   logic        err_halt;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   int exp_word = 0;
   int exp_half = 0;
   int after_br = 0;
   int reads = 0;
   int issues = 0;
   int br_at = -1;
   int br_tgt = 0;
   int br_rs = 0;
   bit held = 1'b0;
   logic [7:0]  h_op;
   logic [11:0] h_addr;
   logic        h_right;
   bit dog_hit = 1'b0;

   always #4 clk = ~clk;

   paired_fetch_seq u_dut (
      .clk       (clk),
      .rst       (rst),
      .mem_rd    (mem_rd),
      .mem_addr  (mem_addr),
      .mem_rdata (mem_rdata),
      .iss_valid (iss_valid),
      .iss_ready (iss_ready),
      .iss_op    (iss_op),
      .iss_addr  (iss_addr),
      .iss_right (iss_right),
      .br_valid  (br_valid),
      .br_target (br_target),
      .br_right  (br_right),
      .err_halt  (err_halt)
   );

   function automatic logic [7:0] op_of(int w, int half);
      logic [11:0] a = 12'(w);
      return (half == 0) ? (a[7:0] ^ 8'h5A) : ~a[7:0];
   endfunction

   function automatic logic [11:0] adr_of(int w, int half);
      return (half == 0) ? 12'(w) : 12'(w * 3 + 7);
   endfunction

   // memory: one-cycle latency, filler value when no strobe (R10)
   always @(posedge clk) begin
      if (mem_rd) begin
         mem_rdata <= {op_of(int'(mem_addr), 0), adr_of(int'(mem_addr), 0),
                       op_of(int'(mem_addr), 1), adr_of(int'(mem_addr), 1)};
      end else begin
         mem_rdata <= 40'hBAD_C0FFEE_0;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step(input bit rdy);
      bit acc;
      bit take;
      cyc++;
      if (cyc > 20000 && !dog_hit) begin
         dog_hit = 1'b1;
         chk(1'b0, "R1", "watchdog expired", cyc, 20000);
      end
      iss_ready = rdy;
      acc  = iss_valid && rdy;
      take = acc && (issues == br_at);
      br_valid  = take;
      br_target = 12'(br_tgt);
      br_right  = (br_rs != 0);
      if (held) begin
         chk(iss_valid && iss_op == h_op && iss_addr == h_addr && iss_right == h_right,
             "R6", "held offer changed", {iss_op, iss_addr}, {h_op, h_addr});
      end
      if (mem_rd) begin
         reads++;
         chk(exp_word <= 999, "R9", "read after range error", int'(mem_addr), -1);
         chk(int'(mem_addr) == exp_word, "R5", "read address", mem_addr, exp_word);
         chk(!(exp_half == 1 && after_br == 0), "R4", "read for held half", 1, 0);
      end
      if (acc) begin
         chk(exp_word <= 999, "R9", "issue after range error", issues, -1);
         chk(iss_op == op_of(exp_word, exp_half), "R2", "opcode",
             iss_op, op_of(exp_word, exp_half));
         chk(iss_addr == adr_of(exp_word, exp_half), "R2", "operand address",
             iss_addr, adr_of(exp_word, exp_half));
         chk(int'(iss_right) == exp_half, "R2", "half flag", iss_right, exp_half);
         if (after_br != 0) begin
            chk(reads == 1, exp_half ? "R8" : "R7", "reads before branch target issue",
                reads, 1);
         end else if (exp_half == 1) begin
            chk(reads == 0, "R4", "reads before right issue", reads, 0);
         end else begin
            chk(reads == 1, "R3", "reads before left issue", reads, 1);
         end
         reads = 0;
         issues++;
         if (take) begin
            exp_word = br_tgt;
            exp_half = br_rs;
            after_br = 1;
         end else begin
            after_br = 0;
            if (exp_half == 0) exp_half = 1;
            else begin
               exp_half = 0;
               exp_word++;
            end
         end
      end
      held = iss_valid && !rdy;
      h_op = iss_op;
      h_addr = iss_addr;
      h_right = iss_right;
      @(negedge clk);
   endtask

   task automatic model_reset();
      exp_word = 0;
      exp_half = 0;
      after_br = 0;
      reads = 0;
      issues = 0;
      held = 1'b0;
      br_at = -1;
   endtask

   initial begin
      @(negedge clk);
      repeat (3) @(negedge clk);
      chk(!iss_valid && !mem_rd && !err_halt, "R1", "outputs in reset",
          {iss_valid, mem_rd, err_halt}, 0);
      rst = 1'b0;
      model_reset();
      // straight line, always ready (R3 R4 R5)
      while (issues < 20 && !dog_hit) step(1'b1);
      // stalled handshake (R6)
      while (issues < 40 && !dog_hit) step((cyc % 3) != 0);
      // left-half branch while a right half is held (R7)
      br_at = 44; br_tgt = 500; br_rs = 0;
      while (issues < 50 && !dog_hit) step((cyc % 4) != 1);
      // right-half branch (R8)
      br_at = 52; br_tgt = 700; br_rs = 1;
      while (issues < 60 && !dog_hit) step(1'b1);
      // walk off the end of memory (R9)
      br_at = 61; br_tgt = 998; br_rs = 0;
      for (int k = 0; k < 300 && !err_halt && !dog_hit; k++) step(1'b1);
      chk(err_halt == 1'b1, "R9", "error after word 999", err_halt, 1);
      chk(exp_word == 1000, "R9", "last word reached", exp_word, 1000);
      for (int k = 0; k < 20; k++) step(1'b1);
      chk(err_halt == 1'b1 && !iss_valid, "R9", "stays halted", err_halt, 1);
      // reset clears the error (R1)
      rst = 1'b1;
      iss_ready = 1'b0;
      br_valid = 1'b0;
      repeat (2) @(negedge clk);
      chk(!err_halt && !iss_valid && !mem_rd, "R1", "error cleared by reset",
          {err_halt, iss_valid, mem_rd}, 0);
      rst = 1'b0;
      model_reset();
      // branch straight to an illegal right half (R8 R9)
      br_at = 1; br_tgt = 1005; br_rs = 1;
      for (int k = 0; k < 100 && !err_halt && !dog_hit; k++) step(1'b1);
      chk(err_halt == 1'b1, "R9", "error on illegal target", err_halt, 1);
      chk(issues == 2, "R9", "issues before halt", issues, 2);
      for (int k = 0; k < 10; k++) step(1'b1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #2000000;
      n_cmp++;
      n_bad++;
      $display("FAIL R1 watchdog: actual %0d expected %0d", cyc, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule